// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single data rate SDRAM from power-up to normal operation. After a one-cycle start pulse it waits for supplies and clocks to settle, holds the bus in NOP, precharges all banks, runs a fixed burst of auto-refresh commands, loads the mode register, and switches the command output to normal mode. Only then does it raise the periodic-refresh enable and a done flag, which pass control to the normal-mode memory controller.

Every wait is a clock-cycle count. The counts are derived at elaboration from the clock frequency in MHz and from delays given in microseconds or nanoseconds, always rounded up. A single down-counter times all the gaps. The command output is registered, so each command shows on the port for exactly one cycle, together with a valid strobe.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until a start pulse is sampled, `cmdValid`, `modeValue`, `refreshEnable` and `initDone` are 0 and `cmdCode` reads NOP (encoding 0).
- R2: The first command is a NOP. Its valid cycle is exactly max(POWER_US*CLK_MHZ, 1) cycles after the clock edge that samples `start`, and no command is issued before it.
- R3: PRECHARGE ALL (encoding 1) follows the NOP after max(NOP_US*CLK_MHZ, NOP_MIN_CLK, 2) cycles.
- R4: The first AUTO REFRESH (encoding 2) follows the precharge after max(ceil(TRP_NS*CLK_MHZ/1000), GAP_US*CLK_MHZ, 2) cycles. Exactly REFRESH_COUNT (default 8) refreshes are issued, each max(ceil(TRC_NS*CLK_MHZ/1000), GAP_US*CLK_MHZ, 2) cycles after the one before.
- R5: MODE REGISTER SET (encoding 3) follows the last refresh by one refresh gap. `modeValue` carries MODE_VALUE (default 0x1D0) in that valid cycle and is 0 in all other cycles.
- R6: NORMAL (encoding 4) follows the mode-register command after max(MRS_CLK, 2) cycles. From its valid cycle on, `cmdCode` stays at NORMAL until reset.
- R7: `refreshEnable` and `initDone` rise in the same cycle, max(GAP_US*CLK_MHZ, 1) cycles after the NORMAL valid cycle, and stay high until reset.
- R8: `cmdValid` is high for exactly one cycle per command. Before NORMAL is issued, `cmdCode` reads NOP in every cycle without a valid command.
- R9: A start pulse that arrives while the sequence is running, or after it has finished, changes neither the command schedule nor any output.
- R10: Reset asserted in the middle of the sequence aborts it and restores the R1 state. A later start pulse runs the full sequence again from the power wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| cmdValid | output | 1 | High for the one cycle in which a command is issued |
| cmdCode | output | 3 | Command encoding: 0 NOP, 1 PRECHARGE ALL, 2 AUTO REFRESH, 3 MODE REGISTER SET, 4 NORMAL |
| modeValue | output | MODE_W | Mode-register value, driven only during the mode-register command |
| refreshEnable | output | 1 | Periodic refresh permitted by the normal-mode controller |
| initDone | output | 1 | Sequence complete |

## Verification
The sequence is run end to end from reset. It is run again with extra start pulses placed in the NOP hold, in the refresh burst and after completion. Any of these stray pulses would shift the schedule if the idle check were missing. A second run is cut off by reset partway through the refreshes and then restarted, which shows that reset clears both the timer and the refresh count. The bench parameters make the tRP and tRC terms larger than the common short gap, and they let the minimum-clock NOP term win over a zero microsecond setting. Off-by-one errors in rounding or in clamp selection therefore appear as shifted command cycles.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_PRECHARGE = 3'd1,
    CMD_REFRESH   = 3'd2,
    CMD_MODESET   = 3'd3,
    CMD_NORMAL    = 3'd4
  } cmdCode_e;

  typedef enum logic [2:0] {
    GAP_POWER,
    GAP_NOP,
    GAP_PRE,
    GAP_REF,
    GAP_MRS,
    GAP_NORM
  } gapSel_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic     issue;
    cmdCode_e code;
    logic     loadTimer;
    gapSel_e  gapSel;
    logic     refLoad;
    logic     refDec;
    logic     finish;
  } ctrlStrobe_t;

  // Nanoseconds to cycles, rounded up.
  function automatic int nsToCycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        timerZero,
  input  logic        refLast,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_POWER, S_NOPW, S_PREW, S_REFW, S_MRSW, S_NORMW, S_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.code      = CMD_NOP;
    strobe.gapSel    = GAP_POWER;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.loadTimer = 1'b1;
          strobe.gapSel    = GAP_POWER;
          stateNext        = S_POWER;
        end
      end
      S_POWER: begin
        if (timerZero) begin
          strobe.issue     = 1'b1;
          strobe.code      = CMD_NOP;
          strobe.loadTimer = 1'b1;
          strobe.gapSel    = GAP_NOP;
          stateNext        = S_NOPW;
        end
      end
      S_NOPW: begin
        if (timerZero) begin
          strobe.issue     = 1'b1;
          strobe.code      = CMD_PRECHARGE;
          strobe.loadTimer = 1'b1;
          strobe.gapSel    = GAP_PRE;
          stateNext        = S_PREW;
        end
      end
      S_PREW: begin
        if (timerZero) begin
          strobe.issue     = 1'b1;
          strobe.code      = CMD_REFRESH;
          strobe.loadTimer = 1'b1;
          strobe.gapSel    = GAP_REF;
          strobe.refLoad   = 1'b1;
          stateNext        = S_REFW;
        end
      end
      S_REFW: begin
        if (timerZero) begin
          strobe.issue     = 1'b1;
          strobe.loadTimer = 1'b1;
          if (refLast) begin
            strobe.code   = CMD_MODESET;
            strobe.gapSel = GAP_MRS;
            stateNext     = S_MRSW;
          end else begin
            strobe.code   = CMD_REFRESH;
            strobe.gapSel = GAP_REF;
            strobe.refDec = 1'b1;
          end
        end
      end
      S_MRSW: begin
        if (timerZero) begin
          strobe.issue     = 1'b1;
          strobe.code      = CMD_NORMAL;
          strobe.loadTimer = 1'b1;
          strobe.gapSel    = GAP_NORM;
          stateNext        = S_NORMW;
        end
      end
      S_NORMW: begin
        if (timerZero) begin
          strobe.finish = 1'b1;
          stateNext     = S_DONE;
        end
      end
      default: stateNext = S_DONE;
    endcase
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> (state != S_IDLE)); // R9

  AST_MRS_AFTER_LAST_REF: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.code == CMD_MODESET) |-> refLast); // R4

  AST_ISSUE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> timerZero); // R3

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int POWER_CYC     = 2,
  parameter int NOP_CYC       = 2,
  parameter int PRE_CYC       = 2,
  parameter int REF_CYC       = 2,
  parameter int MRS_CYC       = 2,
  parameter int NORM_CYC      = 1,
  parameter int TIMER_W       = 4,
  parameter int REFRESH_COUNT = 8,
  parameter int REF_CNT_W     = 4,
  parameter int MODE_W        = 13,
  parameter logic [MODE_W-1:0] MODE_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic              timerZero,
  output logic              refLast,
  output logic              cmdValid,
  output cmdCode_e          cmdCode,
  output logic [MODE_W-1:0] modeValue,
  output logic              refreshEnable,
  output logic              initDone
);

  logic [TIMER_W-1:0]   timer;
  logic [TIMER_W-1:0]   loadVal;
  logic [REF_CNT_W-1:0] refCnt;

  always_comb begin
    unique case (strobe.gapSel)
      GAP_POWER: loadVal = TIMER_W'(POWER_CYC - 1);
      GAP_NOP:   loadVal = TIMER_W'(NOP_CYC - 1);
      GAP_PRE:   loadVal = TIMER_W'(PRE_CYC - 1);
      GAP_REF:   loadVal = TIMER_W'(REF_CYC - 1);
      GAP_MRS:   loadVal = TIMER_W'(MRS_CYC - 1);
      default:   loadVal = TIMER_W'(NORM_CYC - 1);
    endcase
  end

  assign timerZero = (timer == '0);
  assign refLast   = (refCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.loadTimer) timer <= loadVal;
    else if (!timerZero)       timer <= timer - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        refCnt <= '0;
    else if (strobe.refLoad)          refCnt <= REF_CNT_W'(REFRESH_COUNT - 1);
    else if (strobe.refDec && !refLast) refCnt <= refCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid      <= 1'b0;
      cmdCode       <= CMD_NOP;
      modeValue     <= '0;
      refreshEnable <= 1'b0;
      initDone      <= 1'b0;
    end else begin
      cmdValid <= strobe.issue;
      if (strobe.issue)                cmdCode <= strobe.code;
      else if (cmdCode != CMD_NORMAL)  cmdCode <= CMD_NOP;
      modeValue <= (strobe.issue && strobe.code == CMD_MODESET) ? MODE_VALUE : '0;
      if (strobe.finish) begin
        refreshEnable <= 1'b1;
        initDone      <= 1'b1;
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R8

  AST_MODE_ONLY_MRS: assert property (@(posedge clk) disable iff (!rstN)
    (modeValue != '0) |-> (cmdValid && cmdCode == CMD_MODESET)); // R5

  AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_NORMAL) |=> (cmdCode == CMD_NORMAL)); // R6

  AST_REFEN_AFTER_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshEnable) |-> (cmdCode == CMD_NORMAL && !cmdValid)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R7

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int POWER_US      = 200,
  parameter int NOP_US        = 200,
  parameter int NOP_MIN_CLK   = 200,
  parameter int TRP_NS        = 20,
  parameter int TRC_NS        = 70,
  parameter int GAP_US        = 1,
  parameter int MRS_CLK       = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int MODE_W        = 13,
  parameter logic [MODE_W-1:0] MODE_VALUE = MODE_W'(12'h1D0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [MODE_W-1:0] modeValue,
  output logic              refreshEnable,
  output logic              initDone
);

  localparam int GAP_CYC   = GAP_US * CLK_MHZ;
  localparam int POWER_CYC = maxOf(POWER_US * CLK_MHZ, 1);
  localparam int NOP_CYC   = maxOf(maxOf(NOP_US * CLK_MHZ, NOP_MIN_CLK), 2);
  localparam int PRE_CYC   = maxOf(maxOf(nsToCycles(TRP_NS, CLK_MHZ), GAP_CYC), 2);
  localparam int REF_CYC   = maxOf(maxOf(nsToCycles(TRC_NS, CLK_MHZ), GAP_CYC), 2);
  localparam int MRS_CYC   = maxOf(MRS_CLK, 2);
  localparam int NORM_CYC  = maxOf(GAP_CYC, 1);
  localparam int MAX_CYC   = maxOf(maxOf(maxOf(POWER_CYC, NOP_CYC), maxOf(PRE_CYC, REF_CYC)),
                                   maxOf(MRS_CYC, NORM_CYC));
  localparam int TIMER_W   = $clog2(MAX_CYC + 1);
  localparam int REF_CNT_W = $clog2(REFRESH_COUNT) + 1;

  ctrlStrobe_t strobe;
  logic        timerZero;
  logic        refLast;
  cmdCode_e    cmdCodeInt;

  sdram_init_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerZero (timerZero),
    .refLast   (refLast),
    .strobe    (strobe)
  );

  sdram_init_dp #(
    .POWER_CYC     (POWER_CYC),
    .NOP_CYC       (NOP_CYC),
    .PRE_CYC       (PRE_CYC),
    .REF_CYC       (REF_CYC),
    .MRS_CYC       (MRS_CYC),
    .NORM_CYC      (NORM_CYC),
    .TIMER_W       (TIMER_W),
    .REFRESH_COUNT (REFRESH_COUNT),
    .REF_CNT_W     (REF_CNT_W),
    .MODE_W        (MODE_W),
    .MODE_VALUE    (MODE_VALUE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .timerZero     (timerZero),
    .refLast       (refLast),
    .cmdValid      (cmdValid),
    .cmdCode       (cmdCodeInt),
    .modeValue     (modeValue),
    .refreshEnable (refreshEnable),
    .initDone      (initDone)
  );

  assign cmdCode = cmdCodeInt;

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  // Bench configuration: tRP/tRC terms dominate, NOP minimum-clock term wins.
  localparam int MHZ     = 250;
  localparam int PWR_US  = 4;
  localparam int NOPUS   = 0;
  localparam int NOPMIN  = 200;
  localparam int TRPNS   = 20;
  localparam int TRCNS   = 70;
  localparam int GAPUS   = 0;
  localparam int MRSCLK  = 2;
  localparam int NREF    = 8;
  localparam int MODEW   = 13;
  localparam int MODEVAL = 'h1D0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cmdValid;
  logic [2:0] cmdCode;
  logic [MODEW-1:0] modeValue;
  logic refreshEnable;
  logic initDone;

  always #2 clk = ~clk; // 250 MHz

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .POWER_US(PWR_US), .NOP_US(NOPUS), .NOP_MIN_CLK(NOPMIN),
    .TRP_NS(TRPNS), .TRC_NS(TRCNS), .GAP_US(GAPUS), .MRS_CLK(MRSCLK),
    .REFRESH_COUNT(NREF), .MODE_W(MODEW), .MODE_VALUE(MODEW'(MODEVAL))
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .modeValue(modeValue), .refreshEnable(refreshEnable), .initDone(initDone)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference schedule, offsets from the start-sampling edge.
  int evT[NREF + 4];
  int evC[NREF + 4];
  int tDone;
  int idxMrs, idxNorm;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic buildSchedule();
    int gPow, gNop, gPre, gRef, gMrs, gNorm, k;
    gPow  = mx(PWR_US * MHZ, 1);
    gNop  = mx(mx(NOPUS * MHZ, NOPMIN), 2);
    gPre  = mx(mx((TRPNS * MHZ + 999) / 1000, GAPUS * MHZ), 2);
    gRef  = mx(mx((TRCNS * MHZ + 999) / 1000, GAPUS * MHZ), 2);
    gMrs  = mx(MRSCLK, 2);
    gNorm = mx(GAPUS * MHZ, 1);
    evT[0] = gPow;         evC[0] = 0;
    evT[1] = evT[0] + gNop; evC[1] = 1;
    evT[2] = evT[1] + gPre; evC[2] = 2;
    for (int i = 1; i < NREF; i++) begin
      evT[2 + i] = evT[1 + i] + gRef;
      evC[2 + i] = 2;
    end
    k = 2 + NREF;
    idxMrs = k;  evT[k] = evT[k - 1] + gRef; evC[k] = 3;
    idxNorm = k + 1; evT[k + 1] = evT[k] + gMrs; evC[k + 1] = 4;
    tDone = evT[k + 1] + gNorm;
  endtask

  // Model state
  bit started = 1'b0;
  int t = 0;
  string scen = "R1";

  function automatic string phaseTag();
    if (!rstN || !started) return "R1";
    if (t < evT[0]) return "R2";
    if (t < evT[1]) return "R3";
    if (t < evT[idxMrs]) return "R4";
    if (t < evT[idxNorm]) return "R5";
    if (t < tDone) return "R6";
    return "R7";
  endfunction

  task automatic checkNow();
    logic expValid, expRef, expDone;
    logic [2:0] expCode;
    logic [MODEW-1:0] expMode;
    expValid = 1'b0; expCode = 3'd0; expMode = '0; expRef = 1'b0; expDone = 1'b0;
    if (rstN && started) begin
      for (int i = 0; i < NREF + 4; i++)
        if (t == evT[i]) begin expValid = 1'b1; expCode = 3'(evC[i]); end
      if (!expValid && t > evT[idxNorm]) expCode = 3'd4;          // R6 hold
      if (t == evT[idxMrs]) expMode = MODEW'(MODEVAL);              // R5
      if (t >= tDone) begin expRef = 1'b1; expDone = 1'b1; end      // R7
    end
    vectors++;
    // R8: one-cycle valid and NOP between commands are covered by expValid/expCode
    if (cmdValid !== expValid || cmdCode !== expCode || modeValue !== expMode ||
        refreshEnable !== expRef || initDone !== expDone) begin
      miscompares++;
      $display("FAIL %s (scenario %s) t=%0d actual v=%b c=%0d m=%h r=%b d=%b expected v=%b c=%0d m=%h r=%b d=%b",
               phaseTag(), scen, t, cmdValid, cmdCode, modeValue, refreshEnable, initDone,
               expValid, expCode, expMode, expRef, expDone);
    end
  endtask

  task automatic step(input logic s);
    start = s;
    @(posedge clk);
    @(negedge clk);
    if (!rstN) begin
      started = 1'b0; t = 0;
    end else if (!started && s) begin
      started = 1'b1; t = 0;
    end else if (started) begin
      t++;
    end
    start = 1'b0;
    checkNow();
  endtask

  task automatic doReset(input int n);
    rstN = 1'b0;
    for (int i = 0; i < n; i++) step(1'b0);
    rstN = 1'b1;
  endtask

  task automatic runUntil(input int limit);
    while (t < limit) step(1'b0);
  endtask

  initial begin
    buildSchedule();
    @(negedge clk);
    // R1: reset state and idle without start
    scen = "R1";
    doReset(5);
    for (int i = 0; i < 20; i++) step(1'b0);

    // Full sequence R2..R8, with stray starts for R9
    scen = "R2";
    step(1'b1);
    runUntil(evT[0] + 50);
    scen = "R9";
    step(1'b1);                        // during NOP hold
    runUntil(evT[4]);
    step(1'b1);                        // inside refresh burst
    runUntil(tDone + 30);
    step(1'b1);                        // after completion
    for (int i = 0; i < 40; i++) step(1'b0);

    // R10: reset in the middle of refreshes, then rerun
    scen = "R10";
    doReset(3);
    for (int i = 0; i < 10; i++) step(1'b0);
    step(1'b1);
    runUntil(evT[5] + 3);
    doReset(4);
    for (int i = 0; i < 15; i++) step(1'b0);
    step(1'b1);
    runUntil(tDone + 20);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog (scenario %s) actual running expected finished", scen);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule